// File: doc/BRIEF.md
# Clock-to-sample-rate ratio detector

This block works out how many system clock cycles make up one audio frame, where a frame is one period of the word-select signal. It then names the clock mode from that count. The block is a slave: both the system clock and word select come from outside and are frequency-locked to each other. No input tells it which mode is in use.

Word select passes through a synchronizer into the system clock domain. The block times the spacing of its rising edges and matches each measurement against six oversampling ratios: 128, 192, 256, 384, 512 and 768. A classification only becomes the reported mode after it repeats over several frames. The block also flags a ratio that the selected low-sample-rate mode cannot use.

Downstream logic reads the ratio code to set up its filter and clock dividers. It waits for the lock flag before trusting the code.

Top module: `clk_ratio_sense`

## Requirements
- R1: A frame measurement within ±2 cycles of a nominal ratio classifies as that ratio, with code 0=128, 1=192, 2=256, 3=384, 4=512, 5=768. Once locked, `ratio_code_o` shows that code.
- R2: A measurement outside every ±2 window classifies as unknown, code 7. Code 6 never appears.
- R3: `locked_o` rises only after three consecutive measurements give the same known classification. On the measurement that completes the three, the code is loaded with that classification.
- R4: While locked, two consecutive measurements that differ from the locked code drop `locked_o`. A single differing measurement does not. The code keeps its last value while unlocked.
- R5: After each measurement, `error_o` is 1 when that measurement is unknown, or when it differs from the preceding known classification. Otherwise `error_o` is 0. It holds its value between measurements.
- R6: `illegal_o` is 1 exactly when `locked_o` is 1, `low_rate_i` is 1 and the code is 0 or 1.
- R7: When `rst_n` is low at a clock edge, the block clears its count, its lock and its error, and sets the code to 7.
- R8: The first word-select rising edge after reset only starts timing and yields no measurement.
- R9: A frame longer than the counter range saturates the count and classifies as unknown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_sel_i | input | 1 | Word select, asynchronous to clk |
| low_rate_i | input | 1 | 1 = low-sample-rate operating mode |
| ratio_code_o | output | 3 | Detected ratio code (7 = unknown) |
| locked_o | output | 1 | Classification stable over three frames |
| error_o | output | 1 | Last measurement unknown or unstable |
| illegal_o | output | 1 | Locked ratio not allowed in low-rate mode |

## Verification
The hard case is the lock hysteresis. Two mismatching frames must release the lock, the code must stay on its old value, and three frames of a new ratio must then lock onto the new code. The second frame period in the bench is set independently of the first, so the bench can place isolated single-frame glitches, double mismatches and ratio changes wherever it needs them. A long frame drives the counter into saturation. A frame train that starts right after a mid-run reset shows that the first edge only primes the timer.

// File: rtl/crs_pkg.sv
// Shared constants and types for the clock-to-sample-rate ratio detector.
// Assumes the six ratios are listed in ascending order, so code order follows ratio order.
package crs_pkg;
    localparam int NUM_RATIOS = 6;
    localparam int MAX_NOMINAL = 768;
    typedef logic [2:0] ratio_code_t;
    localparam ratio_code_t CODE_UNKNOWN = 3'd7;
    // Codes below this value are not usable in the low-sample-rate mode.
    localparam ratio_code_t LOWRATE_MIN_CODE = 3'd2;

    // Nominal system-clock cycles per frame for each code.
    function automatic int nominal(input int idx);
        case (idx)
            0: return 128;
            1: return 192;
            2: return 256;
            3: return 384;
            4: return 512;
            default: return 768;
        endcase
    endfunction
endpackage

// File: rtl/crs_edge_sync.sv
// Synchronizes an asynchronous level into clk and emits one-cycle rising-edge pulses.
// Assumes STAGES >= 2 and that the input stays at each level for several clk cycles.
module crs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the input through the synchronizer and remember the previous output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/crs_period_counter.sv
// Counts clk cycles between successive edge pulses and publishes each interval.
// The first pulse after reset only arms the counter. The count saturates at its maximum.
module crs_period_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] meas_o,
    output logic             meas_valid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic             armed_q;
    logic [CNT_W-1:0] run_inc;

    assign run_inc = (run_q == CNT_MAX) ? CNT_MAX : run_q + CNT_W'(1);

    // Time the interval, publish it on each pulse and restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q        <= '0;
            armed_q      <= 1'b0;
            meas_o       <= '0;
            meas_valid_o <= 1'b0;
        end else begin
            meas_valid_o <= 1'b0;
            if (tick_i) begin
                run_q   <= '0;
                armed_q <= 1'b1;
                if (armed_q) begin
                    meas_o       <= run_inc;
                    meas_valid_o <= 1'b1;
                end
            end else begin
                run_q <= run_inc;
            end
        end
    end
endmodule

// File: rtl/crs_classifier.sv
// Maps a frame length to a ratio code by checking a ±TOL window around each nominal ratio.
// Assumes the windows do not overlap, which holds for any TOL below 32.
module crs_classifier #(
    parameter int CNT_W = 11,
    parameter int TOL   = 2
) (
    input  logic [CNT_W-1:0]          meas_i,
    output crs_pkg::ratio_code_t      class_o
);
    logic [crs_pkg::NUM_RATIOS-1:0] hit;

    for (genvar g = 0; g < crs_pkg::NUM_RATIOS; g++) begin : g_win
        localparam logic [CNT_W-1:0] LO = CNT_W'(crs_pkg::nominal(g) - TOL);
        localparam logic [CNT_W-1:0] HI = CNT_W'(crs_pkg::nominal(g) + TOL);
        assign hit[g] = (meas_i >= LO) && (meas_i <= HI);
    end

    // Turn the window hits into a code, or unknown when nothing matches.
    always_comb begin
        class_o = crs_pkg::CODE_UNKNOWN;
        for (int i = crs_pkg::NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit[i]) class_o = crs_pkg::ratio_code_t'(i);
        end
    end
endmodule

// File: rtl/crs_lock_tracker.sv
// Builds lock, held code and error from the stream of per-frame classifications.
// Lock needs LOCK_N equal known results. It is released after UNLOCK_N consecutive mismatches.
module crs_lock_tracker #(
    parameter int LOCK_N   = 3,
    parameter int UNLOCK_N = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 meas_valid_i,
    input  crs_pkg::ratio_code_t class_i,
    output crs_pkg::ratio_code_t code_o,
    output logic                 locked_o,
    output logic                 err_o
);
    import crs_pkg::*;
    localparam int AW = $clog2(LOCK_N + 1);
    localparam int MW = $clog2(UNLOCK_N + 1);

    ratio_code_t cand_q, cand_n, code_n;
    logic [AW-1:0] agree_q, agree_n;
    logic [MW-1:0] miss_q, miss_n;
    logic locked_n, err_n;

    // Next-state rules applied once per completed measurement.
    always_comb begin
        cand_n   = cand_q;
        agree_n  = agree_q;
        miss_n   = miss_q;
        locked_n = locked_o;
        code_n   = code_o;
        err_n    = err_o;
        if (meas_valid_i) begin
            err_n = (class_i == CODE_UNKNOWN) ||
                    ((cand_q != CODE_UNKNOWN) && (class_i != cand_q));
            if (class_i == cand_q) begin
                if (agree_q != AW'(LOCK_N)) agree_n = agree_q + AW'(1);
            end else begin
                cand_n  = class_i;
                agree_n = AW'(1);
            end
            if (locked_o) begin
                if (class_i == code_o) begin
                    miss_n = '0;
                end else begin
                    miss_n = miss_q + MW'(1);
                    if (miss_n == MW'(UNLOCK_N)) locked_n = 1'b0;
                end
            end else if ((agree_n == AW'(LOCK_N)) && (cand_n != CODE_UNKNOWN)) begin
                locked_n = 1'b1;
                code_n   = cand_n;
                miss_n   = '0;
            end
        end
    end

    // State registers with synchronous reset to the unknown, unlocked state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q   <= CODE_UNKNOWN;
            agree_q  <= '0;
            miss_q   <= '0;
            locked_o <= 1'b0;
            code_o   <= CODE_UNKNOWN;
            err_o    <= 1'b0;
        end else begin
            cand_q   <= cand_n;
            agree_q  <= agree_n;
            miss_q   <= miss_n;
            locked_o <= locked_n;
            code_o   <= code_n;
            err_o    <= err_n;
        end
    end
endmodule

// File: rtl/clk_ratio_sense.sv
// Top level: detects the system-clock to frame-rate ratio from word select alone.
// Assumes clk and word select are frequency-locked. Word select may arrive with any phase.
module clk_ratio_sense #(
    parameter int TOL         = 2,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_FRAMES = 3,
    parameter int MISS_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_sel_i,
    input  logic       low_rate_i,
    output logic [2:0] ratio_code_o,
    output logic       locked_o,
    output logic       error_o,
    output logic       illegal_o
);
    localparam int CNT_W = $clog2(crs_pkg::MAX_NOMINAL + TOL + 1) + 1;

    logic                 frame_rise;
    logic [CNT_W-1:0]     meas;
    logic                 meas_valid;
    crs_pkg::ratio_code_t frame_class;
    crs_pkg::ratio_code_t code;

    crs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(frame_sel_i), .rise_o(frame_rise));

    crs_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(frame_rise),
        .meas_o(meas), .meas_valid_o(meas_valid));

    crs_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
        .meas_i(meas), .class_o(frame_class));

    crs_lock_tracker #(.LOCK_N(LOCK_FRAMES), .UNLOCK_N(MISS_FRAMES)) u_lock (
        .clk(clk), .rst_n(rst_n), .meas_valid_i(meas_valid), .class_i(frame_class),
        .code_o(code), .locked_o(locked_o), .err_o(error_o));

    assign ratio_code_o = code;
    assign illegal_o = locked_o & low_rate_i & (code < crs_pkg::LOWRATE_MIN_CODE);
endmodule

// File: rtl/crs_checker.sv
// Property checker for clk_ratio_sense, attached by bind.
module crs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       low_rate,
    input logic [2:0] code,
    input logic       locked,
    input logic       err,
    input logic       illegal,
    input logic       meas_valid
);
    // R7: one clock after reset is held, the block sits in its cleared state.
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (code == 3'd7) && !locked && !err);

    // R2: the reserved code never appears.
    a_r2_no_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        code != 3'd6);

    // R3: lock is never taken on an unknown classification.
    a_r3_lock_on_known: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> code != 3'd7);

    // R4: the code cannot change while the lock is held.
    a_r4_code_steady_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(code));

    // R4: while unlocked, the code only moves when the lock is taken again.
    a_r4_code_held_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> ($stable(code) || locked));

    // R5: the error flag moves only right after a measurement.
    a_r5_err_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err) |-> $past(meas_valid));

    // R6: an illegal report needs low-rate mode and a held lock.
    a_r6_illegal_context: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (low_rate && locked));
endmodule

bind clk_ratio_sense crs_checker u_crs_checker (
    .clk(clk), .rst_n(rst_n), .low_rate(low_rate_i), .code(ratio_code_o),
    .locked(locked_o), .err(error_o), .illegal(illegal_o), .meas_valid(meas_valid));

// File: tb/test_clk_ratio_sense.sv
// Bench: drives word-select frames of chosen lengths and compares against a behavioural model.
module test_clk_ratio_sense;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_sel_i = 1'b0;
    logic low_rate_i = 1'b0;
    logic [2:0] ratio_code_o;
    logic locked_o, error_o, illegal_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Model state, built from the requirements.
    int m_cand = 7, m_agree = 0, m_miss = 0, m_code = 7;
    bit m_locked = 0, m_err = 0, have_prev = 0;
    int prev_n = 0;

    clk_ratio_sense i_clk_ratio_sense (
        .clk(clk), .rst_n(rst_n), .frame_sel_i(frame_sel_i), .low_rate_i(low_rate_i),
        .ratio_code_o(ratio_code_o), .locked_o(locked_o), .error_o(error_o),
        .illegal_o(illegal_o));

    always #5 clk = ~clk;

    function automatic int nom(input int i);
        int t[6] = '{128, 192, 256, 384, 512, 768};
        return t[i];
    endfunction

    function automatic int classify(input int n);
        for (int i = 0; i < 6; i++)
            if (n >= nom(i) - 2 && n <= nom(i) + 2) return i;
        return 7;
    endfunction

    task automatic model_reset();
        m_cand = 7; m_agree = 0; m_miss = 0; m_code = 7;
        m_locked = 0; m_err = 0; have_prev = 0;
    endtask

    task automatic model_step(input int n);
        int c;
        c = classify(n);
        m_err = (c == 7) || (m_cand != 7 && c != m_cand);
        if (c == m_cand) begin
            if (m_agree < 3) m_agree++;
        end else begin
            m_cand = c; m_agree = 1;
        end
        if (m_locked) begin
            if (c == m_code) m_miss = 0;
            else begin
                m_miss++;
                if (m_miss == 2) m_locked = 0;
            end
        end else if (m_agree == 3 && m_cand != 7) begin
            m_locked = 1; m_code = m_cand; m_miss = 0;
        end
    endtask

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        bit exp_ill;
        exp_ill = m_locked && low_rate_i && (m_code < 2);
        check(tag, "code (R1/R4)", ratio_code_o, m_code);
        check(tag, "locked (R3/R4)", locked_o, m_locked);
        check(tag, "error (R5)", error_o, m_err);
        check(tag, "illegal (R6)", illegal_o, exp_ill);
    endtask

    // One frame of n cycles starting at a negative edge. The outputs are checked one frame later.
    task automatic frame(input int n, input string tag);
        frame_sel_i = 1'b1;
        repeat (n / 2) @(negedge clk);
        frame_sel_i = 1'b0;
        repeat (n - n / 2) @(negedge clk);
        if (have_prev) model_step(prev_n);
        have_prev = 1;
        prev_n = n;
        check_all(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7", "code after reset", ratio_code_o, 7);
        check("R7", "locked after reset", locked_o, 0);
        check("R7", "error after reset", error_o, 0);
        check("R7", "illegal after reset", illegal_o, 0);
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R8: the first edge after a long idle only arms the counter.
        frame(256, "R8");
        // R1/R2/R3: sweep every ratio across its ±2 window and one cycle beyond.
        for (int i = 0; i < 6; i++)
            for (int d = -3; d <= 3; d++)
                for (int k = 0; k < 4; k++)
                    frame(nom(i) + d, (d == -3 || d == 3) ? "R2" : "R1");
        // R6: the low-rate mode forbids codes 0 and 1 but allows code 2.
        low_rate_i = 1'b1;
        for (int i = 0; i < 3; i++)
            for (int k = 0; k < 4; k++) frame(nom(i), "R6");
        low_rate_i = 1'b0;
        @(negedge clk);
        check_all("R6");
        // R4: a single glitch keeps the lock, a double mismatch drops it, and a new run relocks.
        for (int k = 0; k < 4; k++) frame(256, "R3");
        frame(400, "R4");
        frame(256, "R4");
        for (int k = 0; k < 2; k++) frame(256, "R4");
        for (int k = 0; k < 4; k++) frame(512, "R4");
        // R2/R5: unknown frames raise the error flag and release the lock.
        for (int k = 0; k < 3; k++) frame(300, "R5");
        for (int k = 0; k < 4; k++) frame(384, "R5");
        // R9: very long frames saturate the count and read as unknown.
        for (int k = 0; k < 3; k++) frame(2600, "R9");
        for (int k = 0; k < 4; k++) frame(768, "R9");
        // R7/R8: a reset in mid-run clears everything, and the next edge only primes.
        do_reset();
        frame(192, "R8");
        frame(192, "R8");
        for (int k = 0; k < 3; k++) frame(192, "R3");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule